// File: doc/BRIEF.md
# SPI Master with Level-Flagged FIFOs

This block drives one serial peripheral over a four-wire SPI link (clock, active-low select, data out and data in). Words to send enter through a valid/ready stream and wait in a small transmit FIFO. Each frame's received bits come back, reassembled, through a valid/ready stream that is fed by a receive FIFO. Static control pins set the serial clock rate and mode, the frame length and the bit order. They also set three delays: select to first clock edge, last clock edge to release of the select, and the idle gap between frames. A further pin chooses whether the select drops around each frame or is held low across a run of frames.

Two level flags report how full the FIFOs are. One is high while the transmit FIFO is below a programmed mark. The other is high while the receive FIFO is above a programmed mark. A polling CPU can read both flags at all times. Each flag reaches a shared interrupt line only when its own enable pin is set. Back-pressure works as follows. The transmit side accepts a word in any cycle where tx_valid and tx_ready are both high. tx_ready is low while the FIFO is full, and a word offered then is dropped. The receive side holds rx_data stable while rx_valid is high and rx_ready is low. The engine starts no new frame while the receive FIFO is full, so received data is never lost.

Top module: `spi_wm_master`

## Requirements
- R1: Out of reset, spi_cs_n is high, tx_ready is high and rx_valid is low. While spi_cs_n is high, spi_sck sits at the level of cfg_cpol.
- R2: Successive SCK edges within a frame are exactly cfg_div+1 system clocks apart, which gives an SCK period of 2*(cfg_div+1) clocks.
- R3: With cfg_cpha=0, each data bit is presented before the leading (first) edge of its SCK pulse and sampled on that edge. With cfg_cpha=1, the bit is presented on the leading edge and sampled on the trailing edge. The leading edge moves SCK away from its idle level.
- R4: A frame carries cfg_len bits and produces 2*cfg_len SCK edges. A cfg_len of 0, or one greater than the data width, means the full data width.
- R5: With cfg_lsb_first=0, bit cfg_len-1 goes out first. With cfg_lsb_first=1, bit 0 goes out first. The received word is placed so that a loop-back returns the sent value, right-aligned with zeros above cfg_len.
- R6: Each unit of cfg_cs_lead, cfg_cs_trail and cfg_gap adds exactly one SCK period (2*(cfg_div+1) clocks). These three delays are, in order: select fall to first edge, last edge to select rise, and select-high time between frames.
- R7: With cfg_cs_hold=0, the select falls once per frame and rises after it. With cfg_cs_hold=1, it stays low across consecutive frames and while idle, and it rises only after cfg_cs_hold returns to 0.
- R8: A word offered while the transmit FIFO is full finds tx_ready low and tx_full high. That word is discarded.
- R9: tx_level_pend is high exactly while the transmit FIFO count is below cfg_tx_mark. rx_level_pend is high exactly while the receive FIFO count is above cfg_rx_mark.
- R10: rx_valid is high while the receive FIFO holds data. Words leave in arrival order, and rx_data stays stable while rx_ready is low. Asserting rx_ready while the FIFO is empty has no effect.
- R11: irq is the OR of tx_level_pend gated by cfg_tx_irq_en and rx_level_pend gated by cfg_rx_irq_en.
- R12: No frame starts while the receive FIFO is full. Queued frames go out once a word is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIVW | SCK divisor; half period is cfg_div+1 clocks |
| cfg_cpol | input | 1 | Idle SCK level |
| cfg_cpha | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| cfg_cs_hold | input | 1 | 1 keeps select low between frames |
| cfg_lsb_first | input | 1 | 1 sends bit 0 first |
| cfg_len | input | LENW | Bits per frame |
| cfg_cs_lead | input | DLYW | SCK periods from select fall to first edge |
| cfg_cs_trail | input | DLYW | SCK periods from last edge to select rise |
| cfg_gap | input | DLYW | SCK periods between frames |
| cfg_tx_mark | input | CW | Transmit level mark |
| cfg_rx_mark | input | CW | Receive level mark |
| cfg_tx_irq_en | input | 1 | Routes tx_level_pend to irq |
| cfg_rx_irq_en | input | 1 | Routes rx_level_pend to irq |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Transmit FIFO has room |
| tx_data | input | DW | Transmit word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Consumer takes the word |
| rx_data | output | DW | Oldest received word |
| tx_full | output | 1 | Transmit FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| tx_level_pend | output | 1 | Transmit level below mark |
| rx_level_pend | output | 1 | Receive level above mark |
| irq | output | 1 | Enabled level flags combined |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench builds the block with a FIFO depth of 4, a 4-bit delay field, an 8-bit data width and the default 12-bit divisor, and runs it with cfg_div set to 2. The shallow depth lets a handful of frames fill the receive FIFO and then the transmit FIFO. That exposes the stalled-start rule, the discarded write and both level flags at their exact mark boundaries. The narrow delay field and small divisor keep every delay short enough that the timing differences between delay settings can be measured to the clock. The bench loops MOSI back to MISO and watches the wire, so bit order and sample edges are checked separately from the received word.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_XFER,
    ST_TAIL,
    ST_GAP,
    ST_HELD
  } spi_state_e;
endpackage

// File: rtl/spi_wm_fifo.sv
module spi_wm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= bump(wp);
      if (do_pop)  rp <= bump(rp);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end
endmodule

// File: rtl/spi_wm_engine.sv
module spi_wm_engine
  import spi_wm_pkg::*;
#(
  parameter int DW   = 8,
  parameter int DIVW = 12,
  parameter int DLYW = 8,
  parameter int LENW = $clog2(DW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] cfg_div,
  input  logic            cfg_cpha,
  input  logic            cfg_lsb_first,
  input  logic            cfg_cs_hold,
  input  logic [LENW-1:0] len,
  input  logic [DLYW-1:0] cfg_cs_lead,
  input  logic [DLYW-1:0] cfg_cs_trail,
  input  logic [DLYW-1:0] cfg_gap,
  input  logic            tx_avail,
  input  logic [DW-1:0]   tx_word,
  input  logic            rx_room,
  output logic            tx_pop,
  output logic            rx_push,
  output logic [DW-1:0]   rx_word,
  output logic            sck_act,
  output logic            cs_n,
  output logic            mosi,
  input  logic            miso
);
  localparam int REMW = ((DLYW > LENW) ? DLYW : LENW) + 1;

  spi_state_e      st;
  logic [REMW-1:0] rem;
  logic [DIVW-1:0] hc;
  logic [DW-1:0]   tx_sh, rx_sh, rx_next, load_w;
  logic            tick, lead, smp, chg, start;

  function automatic logic [DW-1:0] rev(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = v[DW-1-i];
    return r;
  endfunction

  assign tick    = (hc == cfg_div);
  assign lead    = ~rem[0];
  assign smp     = (st == ST_XFER) && tick && (lead != cfg_cpha);
  assign chg     = (st == ST_XFER) && tick && (lead == cfg_cpha);
  assign start   = ((st == ST_IDLE) || (st == ST_HELD)) && tx_avail && rx_room;
  assign tx_pop  = start;
  assign load_w  = cfg_lsb_first ? rev(tx_word) : (tx_word << (LENW'(DW) - len));
  assign rx_next = smp ? {rx_sh[DW-2:0], miso} : rx_sh;
  assign rx_word = cfg_lsb_first ? (rev(rx_next) >> (LENW'(DW) - len))
                                 : (rx_next & ~({DW{1'b1}} << len));
  assign rx_push = (st == ST_XFER) && tick && (rem == REMW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      rem     <= '0;
      hc      <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      sck_act <= 1'b0;
      cs_n    <= 1'b1;
      mosi    <= 1'b0;
    end else begin
      hc <= tick ? '0 : hc + 1'b1;
      if (start) begin
        if (cfg_cpha) begin
          tx_sh <= load_w;
        end else begin
          tx_sh <= load_w << 1;
          mosi  <= load_w[DW-1];
        end
        hc <= '0;
      end
      case (st)
        ST_IDLE: if (start) begin
          cs_n <= 1'b0;
          st   <= ST_SETUP;
          rem  <= REMW'({cfg_cs_lead, 1'b0});
        end
        ST_SETUP: if (rem == '0) begin
          st  <= ST_XFER;
          rem <= REMW'({len, 1'b0});
          hc  <= '0;
        end else if (tick) rem <= rem - 1'b1;
        ST_XFER: if (tick) begin
          sck_act <= ~sck_act;
          rx_sh   <= rx_next;
          if (chg) begin
            mosi  <= tx_sh[DW-1];
            tx_sh <= tx_sh << 1;
          end
          rem <= rem - 1'b1;
          if (rem == REMW'(1)) begin
            hc <= '0;
            if (cfg_cs_hold) begin
              st  <= ST_GAP;
              rem <= REMW'({cfg_gap, 1'b0});
            end else begin
              st  <= ST_TAIL;
              rem <= REMW'({cfg_cs_trail, 1'b0});
            end
          end
        end
        ST_TAIL: if (cfg_cs_hold) begin
          st <= ST_HELD;
        end else if (rem == '0) begin
          cs_n <= 1'b1;
          st   <= ST_GAP;
          rem  <= REMW'({cfg_gap, 1'b0});
          hc   <= '0;
        end else if (tick) rem <= rem - 1'b1;
        ST_GAP: if (rem == '0) begin
          st <= cs_n ? ST_IDLE : ST_HELD;
        end else if (tick) rem <= rem - 1'b1;
        ST_HELD: if (start) begin
          st  <= ST_XFER;
          rem <= REMW'({len, 1'b0});
        end else if (!cfg_cs_hold) begin
          st  <= ST_TAIL;
          rem <= REMW'({cfg_cs_trail, 1'b0});
          hc  <= '0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_wm_master.sv
module spi_wm_master #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int DIVW  = 12,
  parameter int DLYW  = 8,
  parameter int LENW  = $clog2(DW + 1),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DIVW-1:0] cfg_div,
  input  logic            cfg_cpol,
  input  logic            cfg_cpha,
  input  logic            cfg_cs_hold,
  input  logic            cfg_lsb_first,
  input  logic [LENW-1:0] cfg_len,
  input  logic [DLYW-1:0] cfg_cs_lead,
  input  logic [DLYW-1:0] cfg_cs_trail,
  input  logic [DLYW-1:0] cfg_gap,
  input  logic [CW-1:0]   cfg_tx_mark,
  input  logic [CW-1:0]   cfg_rx_mark,
  input  logic            cfg_tx_irq_en,
  input  logic            cfg_rx_irq_en,
  input  logic            tx_valid,
  output logic            tx_ready,
  input  logic [DW-1:0]   tx_data,
  output logic            rx_valid,
  input  logic            rx_ready,
  output logic [DW-1:0]   rx_data,
  output logic            tx_full,
  output logic            rx_empty,
  output logic            tx_level_pend,
  output logic            rx_level_pend,
  output logic            irq,
  output logic            spi_sck,
  output logic            spi_cs_n,
  output logic            spi_mosi,
  input  logic            spi_miso
);
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic            tx_empty, rx_full, tx_pop, rx_push, sck_act;
  logic [DW-1:0]   tx_word, rx_word;
  logic [LENW-1:0] len_eff;

  assign len_eff = ((cfg_len == '0) || (cfg_len > LENW'(DW))) ? LENW'(DW) : cfg_len;

  spi_wm_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_valid), .din(tx_data), .pop(tx_pop),
    .dout(tx_word), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  spi_wm_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_word), .pop(rx_ready),
    .dout(rx_data), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  spi_wm_engine #(.DW(DW), .DIVW(DIVW), .DLYW(DLYW), .LENW(LENW)) u_eng (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_cpha(cfg_cpha),
    .cfg_lsb_first(cfg_lsb_first), .cfg_cs_hold(cfg_cs_hold), .len(len_eff),
    .cfg_cs_lead(cfg_cs_lead), .cfg_cs_trail(cfg_cs_trail), .cfg_gap(cfg_gap),
    .tx_avail(!tx_empty), .tx_word(tx_word), .rx_room(!rx_full),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
    .sck_act(sck_act), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso(spi_miso)
  );

  assign tx_ready      = !tx_full;
  assign rx_valid      = !rx_empty;
  assign spi_sck       = sck_act ^ cfg_cpol;
  assign tx_level_pend = (tx_cnt < cfg_tx_mark);
  assign rx_level_pend = (rx_cnt > cfg_rx_mark);
  assign irq = (tx_level_pend && cfg_tx_irq_en) || (rx_level_pend && cfg_rx_irq_en);
endmodule

// File: rtl/spi_wm_master_chk.sv
module spi_wm_master_chk #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_cpol,
  input logic          cfg_cs_hold,
  input logic [CW-1:0] cfg_tx_mark,
  input logic          spi_cs_n,
  input logic          spi_sck,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic [DW-1:0] rx_data,
  input logic          rx_level_pend,
  input logic          tx_full,
  input logic          tx_level_pend
);
  a_r1_sck_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> (spi_sck == cfg_cpol));

  a_r7_hold_keeps_select: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cs_hold && !spi_cs_n) |=> !spi_cs_n);

  a_r10_rx_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  a_r9_rx_pend_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level_pend |-> rx_valid);

  a_r9_tx_pend_clear_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_full && (cfg_tx_mark <= CW'(DEPTH))) |-> !tx_level_pend);
endmodule

bind spi_wm_master spi_wm_master_chk #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cs_hold(cfg_cs_hold),
  .cfg_tx_mark(cfg_tx_mark), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
  .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .rx_level_pend(rx_level_pend), .tx_full(tx_full), .tx_level_pend(tx_level_pend)
);

// File: tb/spi_wm_master_bench.sv
`timescale 1ns/1ps
module spi_wm_master_bench;
  localparam int DW = 8, DEPTH = 4, DIVW = 12, DLYW = 4;
  localparam int LENW = $clog2(DW + 1), CW = $clog2(DEPTH + 1);
  localparam int HP = 3;

  logic clk = 0, rst_n = 0;
  logic [DIVW-1:0] cfg_div = DIVW'(HP - 1);
  logic cfg_cpol = 0, cfg_cpha = 0, cfg_cs_hold = 0, cfg_lsb_first = 0;
  logic [LENW-1:0] cfg_len = LENW'(8);
  logic [DLYW-1:0] cfg_cs_lead = 0, cfg_cs_trail = 0, cfg_gap = 0;
  logic [CW-1:0] cfg_tx_mark = CW'(1), cfg_rx_mark = 0;
  logic cfg_tx_irq_en = 0, cfg_rx_irq_en = 0;
  logic tx_valid = 0, rx_ready = 0;
  logic [DW-1:0] tx_data = 0;
  logic tx_ready, rx_valid, tx_full, rx_empty, tx_level_pend, rx_level_pend, irq;
  logic [DW-1:0] rx_data;
  logic spi_sck, spi_cs_n, spi_mosi;

  always #2.5 clk = ~clk;

  spi_wm_master #(.DW(DW), .DEPTH(DEPTH), .DIVW(DIVW), .DLYW(DLYW)) u_spi_wm_master (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .cfg_cs_hold(cfg_cs_hold), .cfg_lsb_first(cfg_lsb_first), .cfg_len(cfg_len),
    .cfg_cs_lead(cfg_cs_lead), .cfg_cs_trail(cfg_cs_trail), .cfg_gap(cfg_gap),
    .cfg_tx_mark(cfg_tx_mark), .cfg_rx_mark(cfg_rx_mark),
    .cfg_tx_irq_en(cfg_tx_irq_en), .cfg_rx_irq_en(cfg_rx_irq_en),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_full(tx_full), .rx_empty(rx_empty), .tx_level_pend(tx_level_pend),
    .rx_level_pend(rx_level_pend), .irq(irq), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_mosi)
  );

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done = 0;
  int n_edges, t_first, t_last, min_hp, max_hp, n_fall, n_rise, t_fall, t_rise, hi_time;
  logic [7:0] wire_bits;
  logic sck_q = 0, cs_q = 1;

  always @(posedge clk) cyc++;

  // wire monitor: edges, sample-edge bits, select timing
  always @(negedge clk) begin
    if (cs_q && !spi_cs_n) begin
      n_fall++; t_fall = cyc;
      if (n_rise > 0) hi_time = cyc - t_rise;
    end
    if (!cs_q && spi_cs_n) begin n_rise++; t_rise = cyc; end
    if (sck_q != spi_sck && !spi_cs_n) begin
      if (n_edges == 0) t_first = cyc;
      else begin
        if (cyc - t_last < min_hp) min_hp = cyc - t_last;
        if (cyc - t_last > max_hp) max_hp = cyc - t_last;
      end
      t_last = cyc; n_edges++;
      if ((spi_sck != cfg_cpol) != cfg_cpha) wire_bits = {wire_bits[6:0], spi_mosi};
    end
    sck_q = spi_sck; cs_q = spi_cs_n;
  end

  task automatic mon_clear();
    n_edges = 0; t_first = 0; t_last = 0; min_hp = 1000000; max_hp = 0;
    n_fall = 0; n_rise = 0; t_fall = 0; t_rise = 0; hi_time = 0; wire_bits = 0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", tag, act, act, exp, exp);
    end
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk); tx_data = d; tx_valid = 1;
    @(negedge clk); tx_valid = 0;
  endtask

  task automatic pull(output logic [7:0] d);
    @(negedge clk);
    while (!rx_valid) @(negedge clk);
    d = rx_data; rx_ready = 1;
    @(negedge clk); rx_ready = 0;
  endtask

  task automatic settle(); repeat (80) @(negedge clk); endtask

  task automatic one_frame(input logic [7:0] d, output logic [7:0] r);
    mon_clear(); push(d); pull(r); settle();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 cs_n after reset", spi_cs_n, 1);
    chk("R1 sck idle low", spi_sck, 0);
    chk("R1 tx_ready", tx_ready, 1);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R9 tx pend empty fifo mark 1", tx_level_pend, 1);
    chk("R9 rx pend empty", rx_level_pend, 0);
    chk("R11 irq disabled", irq, 0);
  endtask

  task automatic t_mode(input logic pol, input logic pha, input logic [7:0] d);
    logic [7:0] r;
    cfg_cpol = pol; cfg_cpha = pha; @(negedge clk);
    chk("R1 R3 idle sck level", spi_sck, pol);
    one_frame(d, r);
    chk("R3 R5 loopback word", r, d);
    chk("R3 R5 wire bits msb first", wire_bits, d);
    chk("R4 edge count", n_edges, 16);
    chk("R2 min half period", min_hp, HP);
    chk("R2 max half period", max_hp, HP);
    chk("R3 sck back to idle", spi_sck, pol);
  endtask

  task automatic t_order_len();
    logic [7:0] r;
    cfg_cpol = 0; cfg_cpha = 0; cfg_lsb_first = 1;
    one_frame(8'h01, r);
    chk("R5 lsb first word", r, 8'h01);
    chk("R5 lsb first wire", wire_bits, 8'h80);
    cfg_lsb_first = 0; cfg_len = LENW'(5);
    one_frame(8'h16, r);
    chk("R4 len5 edges", n_edges, 10);
    chk("R5 len5 word", r, 8'h16);
    chk("R5 len5 wire", wire_bits & 8'h1F, 8'h16);
    cfg_len = 0;
    one_frame(8'hC3, r);
    chk("R4 len0 means full width", n_edges, 16);
    cfg_len = LENW'(8);
  endtask

  task automatic t_delays();
    logic [7:0] r;
    int d0, d2, e0, e1, g0, g2;
    one_frame(8'h11, r); d0 = t_first - t_fall; e0 = t_rise - t_last;
    cfg_cs_lead = 2; cfg_cs_trail = 1;
    one_frame(8'h22, r); d2 = t_first - t_fall; e1 = t_rise - t_last;
    chk("R6 lead delay step", d2 - d0, 4 * HP);
    chk("R6 trail delay step", e1 - e0, 2 * HP);
    cfg_cs_lead = 0; cfg_cs_trail = 0;
    mon_clear(); push(8'h33); push(8'h44); pull(r); pull(r); settle(); g0 = hi_time;
    chk("R7 auto mode select rises per frame", n_rise, 2);
    cfg_gap = 2;
    mon_clear(); push(8'h55); push(8'h66); pull(r); pull(r); settle(); g2 = hi_time;
    chk("R6 gap step", g2 - g0, 4 * HP);
    cfg_gap = 0;
  endtask

  task automatic t_hold();
    logic [7:0] r;
    cfg_cs_hold = 1; mon_clear();
    push(8'hA1); push(8'hA2); push(8'hA3);
    pull(r); chk("R7 hold word 1", r, 8'hA1);
    pull(r); pull(r); chk("R7 hold word 3", r, 8'hA3);
    settle();
    chk("R7 hold single fall", n_fall, 1);
    chk("R7 hold no rise", n_rise, 0);
    chk("R7 select held idle", spi_cs_n, 0);
    cfg_cs_hold = 0; settle();
    chk("R7 release after hold cleared", spi_cs_n, 1);
    chk("R7 one rise", n_rise, 1);
  endtask

  task automatic t_fifo();
    logic [7:0] r;
    for (int i = 0; i < 4; i++) push(8'h10 + 8'(i));
    repeat (400) @(negedge clk);
    chk("R12 rx fifo filled", rx_valid, 1);
    cfg_rx_mark = 0; @(negedge clk); chk("R9 rx pend mark0", rx_level_pend, 1);
    cfg_rx_mark = 3; @(negedge clk); chk("R9 rx pend 4>3", rx_level_pend, 1);
    cfg_rx_mark = 4; @(negedge clk); chk("R9 rx pend 4>4", rx_level_pend, 0);
    for (int i = 4; i < 8; i++) push(8'h10 + 8'(i));
    repeat (200) @(negedge clk);
    chk("R12 no start while rx full", tx_full, 1);
    chk("R8 tx_ready low when full", tx_ready, 0);
    cfg_tx_mark = 4; @(negedge clk); chk("R9 tx pend 4<4", tx_level_pend, 0);
    cfg_tx_mark = 5; @(negedge clk); chk("R9 tx pend 4<5", tx_level_pend, 1);
    cfg_rx_mark = 0; @(negedge clk);
    chk("R11 irq gated off", irq, 0);
    cfg_tx_irq_en = 1; @(negedge clk); chk("R11 irq from tx", irq, 1);
    cfg_tx_irq_en = 0; cfg_rx_irq_en = 1; @(negedge clk); chk("R11 irq from rx", irq, 1);
    cfg_rx_mark = 4; @(negedge clk); chk("R11 irq rx below mark", irq, 0);
    cfg_rx_irq_en = 0; cfg_rx_mark = 0; cfg_tx_mark = 1;
    push(8'hEE);
    for (int i = 0; i < 8; i++) begin
      pull(r);
      chk("R10 R8 R12 arrival order", r, 8'h10 + i);
    end
    repeat (300) @(negedge clk);
    chk("R8 dropped word never sent", rx_valid, 0);
    rx_ready = 1; repeat (3) @(negedge clk); rx_ready = 0;
    chk("R10 empty read no pend", rx_level_pend, 0);
    push(8'h42); pull(r);
    chk("R10 word after empty read", r, 8'h42);
    repeat (100) @(negedge clk);
    chk("R10 nothing extra", rx_valid, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    mon_clear();
    repeat (5) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_mode(0, 0, 8'hA5);
    t_mode(1, 1, 8'h3C);
    t_mode(0, 1, 8'h96);
    t_mode(1, 0, 8'h5A);
    t_order_len();
    t_delays();
    t_hold();
    t_fifo();
    finish_run();
  end
endmodule